// File: doc/BRIEF.md
# Memory-Mapped Serial and Parallel I/O Peripheral

This block sits on the load/store bus of a small processor and gives it three things: an 8-bit output latch, a view of eight input pins, and a one-byte-each-way asynchronous serial port. The processor reaches all of it through four 32-bit words starting at a base address. There is no queueing in the serial path, so a program polls a status word before each transmit and after each receive.

The serial line uses a fixed bit time of 128 clock cycles, for example 93750 baud from a 12 MHz clock. Frames are 8N1: a low start bit, eight data bits least significant first, and a high stop bit. The receiver resynchronises the line through a flop chain and finds the start edge. It confirms the start bit half a bit later, then samples every following bit at its centre. A received byte sits in a single holding register until software reads it. A ready-to-send output tells the far end whether that register is free.

Bus reads are combinational from the address while the read strobe is high. Side effects take place at the clock edge that ends the access: a write loads a register or starts a frame, and a read of the serial data word empties the holding register.

Top module: `mmio_serial_io`

## Requirements
- R1: After reset, the output latch is 0x00, the transmit line is high, the ready-to-send output is low and the status word reads 0.
- R2: A write to base+0x0 loads bits 7:0 of the write data into the output latch. Writes to any other address leave the latch unchanged.
- R3: A read of base+0x4 returns the eight input pins in bits 7:0, with zeros above.
- R4: A read of any address other than the four mapped words returns zero, and the read-data bus is zero while the read strobe is low.
- R5: A write to base+0x10 while the transmitter is idle sends one 8N1 frame of bits 7:0 on the transmit line. The start bit begins at the clock edge of the write, each bit lasts 128 cycles, and the line is high while idle.
- R6: Status bit 0 (base+0x14) is set from the edge of the accepting write and stays set for exactly 10×128 cycles.
- R7: A write to base+0x10 while status bit 0 is set is discarded and produces no frame.
- R8: When a frame with a high stop bit has been received, status bit 1 becomes set and a read of base+0x10 returns the byte in bits 7:0.
- R9: A read of base+0x10 clears status bit 1. The ready-to-send output is high exactly while status bit 1 is set.
- R10: A byte that arrives while status bit 1 is still set replaces the held byte.
- R11: A low pulse on the receive line that has ended by the start bit's midpoint (64 cycles after the edge) is discarded, and the receiver still accepts the next valid frame.
- R12: A frame whose stop bit samples low is discarded: status bit 1 stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the serial bit-time reference |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| gpi | input | 8 | General-purpose input pins |
| gpo | output | 8 | General-purpose output latch |
| uart_rx | input | 1 | Serial receive line (asynchronous) |
| uart_tx | output | 1 | Serial transmit line |
| uart_rts | output | 1 | Ready-to-send; high while a received byte is waiting |

## Verification
The bench builds the block with its defaults: a 128-cycle bit time, a two-stage synchroniser and base address 0x1000_0000. The serial timing is therefore checked at its real value, including the 1280-cycle busy window and the 64-cycle start-bit confirmation. A frame costs only about 1300 cycles, so the full bit time fits easily in a short run. The same holds for the glitch and bad-stop-bit cases, which need the receiver's full state sequence to reach its midpoint decisions.

// File: rtl/mmio_serial_pkg.sv
package mmio_serial_pkg;

  localparam int BUS_W        = 32;
  localparam int BYTE_W       = 8;
  localparam int FRAME_LEN    = BYTE_W + 2;

  localparam logic [BUS_W-1:0] OFS_GPO  = 32'h0000_0000;
  localparam logic [BUS_W-1:0] OFS_GPI  = 32'h0000_0004;
  localparam logic [BUS_W-1:0] OFS_DATA = 32'h0000_0010;
  localparam logic [BUS_W-1:0] OFS_STAT = 32'h0000_0014;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GPO,
    SEL_GPI,
    SEL_DATA,
    SEL_STAT
  } reg_sel_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // Map a full byte address onto one of the four words.
  function automatic reg_sel_e decode_sel(input logic [BUS_W-1:0] addr,
                                          input logic [BUS_W-1:0] base);
    reg_sel_e s;
    if (addr == base + OFS_GPO)       s = SEL_GPO;
    else if (addr == base + OFS_GPI)  s = SEL_GPI;
    else if (addr == base + OFS_DATA) s = SEL_DATA;
    else if (addr == base + OFS_STAT) s = SEL_STAT;
    else                              s = SEL_NONE;
    return s;
  endfunction

  // Line levels of one 8N1 frame, element 0 goes out first.
  function automatic logic [FRAME_LEN-1:0] frame_bits(input logic [BYTE_W-1:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  // Status word: bit 1 byte waiting, bit 0 transmit busy.
  function automatic logic [BUS_W-1:0] status_word(input logic full, input logic busy);
    return {{(BUS_W-2){1'b0}}, full, busy};
  endfunction

  function automatic logic [BUS_W-1:0] widen_byte(input logic [BYTE_W-1:0] b);
    return {{(BUS_W-BYTE_W){1'b0}}, b};
  endfunction

endpackage

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx
  import mmio_serial_pkg::*;
#(
  parameter int CLKS_PER_BIT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] data,
  output logic              busy,
  output logic              tx
);

  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam int BW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [BW-1:0] BITS_LAST = BW'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] shreg;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        left;
  logic                 busy_q;
  logic                 bit_end;

  assign bit_end = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '1;
      cnt    <= '0;
      left   <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        shreg  <= frame_bits(data);
        cnt    <= CNT_LAST;
        left   <= BITS_LAST;
        busy_q <= 1'b1;
      end
    end else if (bit_end) begin
      cnt <= CNT_LAST;
      if (left == '0) begin
        busy_q <= 1'b0;
      end else begin
        shreg <= {1'b1, shreg[FRAME_LEN-1:1]};
        left  <= left - 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = busy_q;
  assign tx   = shreg[0];

endmodule

// File: rtl/mmio_uart_rx.sv
module mmio_uart_rx
  import mmio_serial_pkg::*;
#(
  parameter int CLKS_PER_BIT = 128,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pin,
  output logic              done,
  output logic [BYTE_W-1:0] byte_out
);

  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam int IW = $clog2(BYTE_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sync;
  logic                   rx_s;
  logic                   rx_prev;
  rx_state_e              state;
  logic [CW-1:0]          cnt;
  logic [IW-1:0]          idx;
  logic [BYTE_W-1:0]      sh;
  logic                   tick;
  logic                   fall;

  // Synchroniser chain, length chosen by parameter.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) sync <= '1;
        else        sync <= rx_pin;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (!rst_n) sync <= '1;
        else        sync <= {sync[SYNC_STAGES-2:0], rx_pin};
      end
    end
  endgenerate

  assign rx_s = sync[SYNC_STAGES-1];
  assign tick = (cnt == '0);
  assign fall = rx_prev && !rx_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_prev  <= 1'b1;
      state    <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      sh       <= '0;
      done     <= 1'b0;
      byte_out <= '0;
    end else begin
      rx_prev <= rx_s;
      done    <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (fall) begin
            state <= RX_START;
            cnt   <= HALF_LAST;
          end
        end
        RX_START: begin
          if (!tick) begin
            cnt <= cnt - 1'b1;
          end else if (!rx_s) begin
            state <= RX_DATA;
            cnt   <= CNT_LAST;
            idx   <= '0;
          end else begin
            state <= RX_IDLE;
          end
        end
        RX_DATA: begin
          if (!tick) begin
            cnt <= cnt - 1'b1;
          end else begin
            sh  <= {rx_s, sh[BYTE_W-1:1]};
            cnt <= CNT_LAST;
            if (idx == IDX_LAST) state <= RX_STOP;
            else                 idx   <= idx + 1'b1;
          end
        end
        RX_STOP: begin
          if (!tick) begin
            cnt <= cnt - 1'b1;
          end else begin
            state <= RX_IDLE;
            if (rx_s) begin
              done     <= 1'b1;
              byte_out <= sh;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mmio_bus_decode.sv
module mmio_bus_decode
  import mmio_serial_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h1000_0000
) (
  input  logic [BUS_W-1:0]  addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] gpi,
  input  logic [BYTE_W-1:0] rx_hold,
  input  logic              rx_full,
  input  logic              tx_busy,
  output logic              gpo_wr,
  output logic              data_wr,
  output logic              data_rd,
  output logic              unmapped,
  output logic [BUS_W-1:0]  rdata
);

  reg_sel_e sel;

  assign sel      = decode_sel(addr, BASE_ADDR);
  assign gpo_wr   = wr && (sel == SEL_GPO);
  assign data_wr  = wr && (sel == SEL_DATA);
  assign data_rd  = rd && (sel == SEL_DATA);
  assign unmapped = (sel == SEL_NONE);

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (sel)
        SEL_GPI:  rdata = widen_byte(gpi);
        SEL_DATA: rdata = widen_byte(rx_hold);
        SEL_STAT: rdata = status_word(rx_full, tx_busy);
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mmio_serial_io.sv
module mmio_serial_io
  import mmio_serial_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR    = 32'h1000_0000,
  parameter int          CLKS_PER_BIT = 128,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  gpi,
  output logic [7:0]  gpo,
  input  logic        uart_rx,
  output logic        uart_tx,
  output logic        uart_rts
);

  // Named internal events, observed by the bound checker.
  logic              gpo_wr;
  logic              data_wr;
  logic              data_rd;
  logic              sel_unmapped;
  logic              tx_start;
  logic              tx_busy;
  logic              rx_done;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] rx_hold;
  logic              rx_full;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:BYTE_W];

  mmio_bus_decode #(
    .BASE_ADDR (BASE_ADDR)
  ) u_decode (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .gpi      (gpi),
    .rx_hold  (rx_hold),
    .rx_full  (rx_full),
    .tx_busy  (tx_busy),
    .gpo_wr   (gpo_wr),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .unmapped (sel_unmapped),
    .rdata    (bus_rdata)
  );

  // Writes that land while a frame is in flight are dropped here.
  assign tx_start = data_wr && !tx_busy;

  mmio_uart_tx #(
    .CLKS_PER_BIT (CLKS_PER_BIT)
  ) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_start),
    .data  (bus_wdata[BYTE_W-1:0]),
    .busy  (tx_busy),
    .tx    (uart_tx)
  );

  mmio_uart_rx #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_pin   (uart_rx),
    .done     (rx_done),
    .byte_out (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpo <= '0;
    end else if (gpo_wr) begin
      gpo <= bus_wdata[BYTE_W-1:0];
    end
  end

  // Single holding register; a new arrival wins over a same-cycle read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hold <= '0;
      rx_full <= 1'b0;
    end else if (rx_done) begin
      rx_hold <= rx_byte;
      rx_full <= 1'b1;
    end else if (data_rd) begin
      rx_full <= 1'b0;
    end
  end

  assign uart_rts = rx_full;

endmodule

// File: rtl/mmio_serial_io_chk.sv
module mmio_serial_io_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic [7:0]  gpo,
  input logic        uart_tx,
  input logic        tx_busy,
  input logic        tx_start,
  input logic        gpo_wr,
  input logic        data_rd,
  input logic        rx_done,
  input logic        rx_full,
  input logic        sel_unmapped
);

  AST_GPO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gpo_wr |=> $stable(gpo)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_unmapped) |-> (bus_rdata == 32'h0)); // R4

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> uart_tx); // R5

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !uart_tx); // R5

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_start)); // R6

  AST_RX_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_full); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_done) |=> !rx_full); // R9

endmodule

bind mmio_serial_io mmio_serial_io_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .gpo          (gpo),
  .uart_tx      (uart_tx),
  .tx_busy      (tx_busy),
  .tx_start     (tx_start),
  .gpo_wr       (gpo_wr),
  .data_rd      (data_rd),
  .rx_done      (rx_done),
  .rx_full      (rx_full),
  .sel_unmapped (sel_unmapped)
);

// File: tb/test_mmio_serial_io.sv
module test_mmio_serial_io;

  localparam int          BIT  = 128;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] A_GPO  = BASE;
  localparam logic [31:0] A_GPI  = BASE + 32'h4;
  localparam logic [31:0] A_DATA = BASE + 32'h10;
  localparam logic [31:0] A_STAT = BASE + 32'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  gpi = '0;
  logic [7:0]  gpo;
  logic        uart_rx = 1'b1;
  logic        uart_tx;
  logic        uart_rts;

  int checks = 0;
  int errors = 0;
  int frames_seen = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  mmio_serial_io i_mmio_serial_io (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .gpi       (gpi),
    .gpo       (gpo),
    .uart_rx   (uart_rx),
    .uart_tx   (uart_tx),
    .uart_rts  (uart_rts)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bus tasks are entered at a falling edge and return at the next one.
  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = '0;
  endtask

  // Driver: every accepted byte becomes an expected frame.
  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    bus_write(A_DATA, {24'h0, b});
  endtask

  task automatic rx_frame(input logic [7:0] b, input logic stop);
    logic [9:0] lvl;
    lvl = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      uart_rx = lvl[i];
      repeat (BIT) @(negedge clk);
    end
    uart_rx = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: decodes frames from the line and pops the scoreboard.
  initial begin
    logic [7:0] got;
    logic [7:0] want;
    forever begin
      @(negedge clk);
      if (rst_n && uart_tx === 1'b0) begin
        repeat (BIT/2 - 1) @(negedge clk);
        check(uart_tx == 1'b0, "R5", "start bit at midpoint", {31'h0, uart_tx}, 32'h0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          got[i] = uart_tx;
        end
        repeat (BIT) @(negedge clk);
        check(uart_tx == 1'b1, "R5", "stop bit level", {31'h0, uart_tx}, 32'h1);
        frames_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected frame", {24'h0, got}, 32'h0);
        end else begin
          want = exp_q.pop_front();
          check(got == want, "R5", "frame byte", {24'h0, got}, {24'h0, want});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not complete actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int busy_n;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(gpo == 8'h00, "R1", "gpo after reset", {24'h0, gpo}, 32'h0);
    check(uart_tx == 1'b1, "R1", "tx idle after reset", {31'h0, uart_tx}, 32'h1);
    check(uart_rts == 1'b0, "R1", "rts after reset", {31'h0, uart_rts}, 32'h0);
    bus_read(A_STAT, r);
    check(r == 32'h0, "R1", "status after reset", r, 32'h0);

    // R2 output latch
    bus_write(A_GPO, 32'hFFFF_FFA5);
    check(gpo == 8'hA5, "R2", "gpo load", {24'h0, gpo}, 32'hA5);
    bus_write(A_GPI, 32'h0000_00FF);
    bus_write(A_STAT, 32'h0000_0011);
    bus_write(BASE + 32'h8, 32'h0000_0077);
    check(gpo == 8'hA5, "R2", "gpo kept on other writes", {24'h0, gpo}, 32'hA5);
    bus_write(A_GPO, 32'h0000_003C);
    check(gpo == 8'h3C, "R2", "gpo reload", {24'h0, gpo}, 32'h3C);

    // R3 input pins
    gpi = 8'h5A;
    bus_read(A_GPI, r);
    check(r == 32'h5A, "R3", "gpi read", r, 32'h5A);
    gpi = 8'hC3;
    bus_read(A_GPI, r);
    check(r == 32'hC3, "R3", "gpi read second", r, 32'hC3);

    // R4 unmapped and idle bus
    bus_read(BASE + 32'h8, r);
    check(r == 32'h0, "R4", "unmapped in window", r, 32'h0);
    bus_read(32'h2000_0004, r);
    check(r == 32'h0, "R4", "unmapped far", r, 32'h0);
    bus_addr = A_GPI;
    #1 check(bus_rdata == 32'h0, "R4", "rdata with rd low", bus_rdata, 32'h0);
    @(negedge clk);
    bus_addr = '0;

    // R5, R6 transmit one byte and measure the busy window
    send_byte(8'h55);
    busy_n = 0;
    for (int k = 0; k < 1400; k++) begin
      bus_read(A_STAT, r);
      if (r[0]) busy_n++;
      else break;
    end
    check(busy_n == 10 * BIT, "R6", "busy cycles", busy_n, 10 * BIT);
    wait_cycles(20);

    // R7 write while busy is dropped
    send_byte(8'hA3);
    wait_cycles(5);
    bus_write(A_DATA, 32'h0000_000F);
    wait_cycles(10 * BIT + 200);
    bus_read(A_STAT, r);
    check(r[0] == 1'b0, "R6", "busy clear after frame", r, 32'h0);
    check(frames_seen == 2, "R7", "frames after ignored write", frames_seen, 2);
    check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

    // R8, R9 receive and read back
    rx_frame(8'h96, 1'b1);
    check(uart_rts == 1'b1, "R9", "rts while byte waits", {31'h0, uart_rts}, 32'h1);
    bus_read(A_STAT, r);
    check(r == 32'h2, "R8", "status byte waiting", r, 32'h2);
    bus_read(A_DATA, r);
    check(r == 32'h96, "R8", "received byte", r, 32'h96);
    bus_read(A_STAT, r);
    check(r == 32'h0, "R9", "status cleared by read", r, 32'h0);
    check(uart_rts == 1'b0, "R9", "rts after read", {31'h0, uart_rts}, 32'h0);

    // R10 overwrite
    rx_frame(8'h11, 1'b1);
    rx_frame(8'hE7, 1'b1);
    bus_read(A_DATA, r);
    check(r == 32'hE7, "R10", "newer byte kept", r, 32'hE7);

    // R11 short glitch
    uart_rx = 1'b0;
    wait_cycles(30);
    uart_rx = 1'b1;
    wait_cycles(2000);
    bus_read(A_STAT, r);
    check(r[1] == 1'b0, "R11", "glitch rejected", r, 32'h0);
    rx_frame(8'h42, 1'b1);
    bus_read(A_DATA, r);
    check(r == 32'h42, "R11", "frame after glitch", r, 32'h42);

    // R12 bad stop bit
    rx_frame(8'h24, 1'b0);
    wait_cycles(BIT);
    bus_read(A_STAT, r);
    check(r[1] == 1'b0, "R12", "bad stop dropped", r, 32'h0);
    rx_frame(8'h81, 1'b1);
    bus_read(A_DATA, r);
    check(r == 32'h81, "R12", "frame after bad stop", r, 32'h81);

    check(frames_seen == 2, "R7", "no late frames", frames_seen, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule